// File: doc/BRIEF.md
# Serial Clock Low-Time Watchdog

This block watches the sampled level of a two-wire serial bus clock line and declares a bus error when that line has been held low for longer than a programmed limit. Time is measured in pulses of a prescaled tick input. Each pulse marks one fixed time unit of 143.36 us. A configuration byte supplies an enable flag and a 7-bit limit. The allowed low time is (limit + 1) tick units. Every change of level on the clock line restarts the measurement.

Once the limit is exceeded, the block raises a one-cycle error strobe that feeds the interrupt request. It also presents the bus-error status code 78h for the status register and asks the bus pad logic to release both the clock and the data lines. All three results hold until the host applies reset. The same mechanism covers two situations: a transfer stalled mid-byte, and a master waiting to issue a start condition while another device keeps the clock low. Clock generation and the protocol state machine sit elsewhere.

Top module: `sclLowWatchdog`

## Requirements
- R1: After reset, `statusCode` reads F8h (idle), and `errStrobe`, `sclRelease` and `sdaRelease` are all 0.
- R2: Bit 7 of `cfgByte` enables the watchdog and bits 6:0 hold the limit V. With the clock line low and enabled, the error is declared on the (V+1)-th `tick` pulse counted since the line last changed level. No error is declared on any earlier pulse.
- R3: `tick` pulses that arrive while the clock line is high are not counted.
- R4: Any transition of the clock line, rising or falling, reloads the count from `cfgByte[6:0]`. A new low period therefore gets the full (V+1) pulses again.
- R5: While bit 7 of `cfgByte` is 0, no error can occur, and the count is held at the reload value. After re-enabling, the full (V+1) pulses are needed.
- R6: On the error, `errStrobe` is 1 for exactly one cycle, `statusCode` becomes 78h, and `sclRelease` and `sdaRelease` both become 1.
- R7: The error state is sticky. Clock transitions, further ticks and clearing the enable bit do not leave it; only `rstN` returns the block to F8h with both releases at 0.
- R8: Limit 0 expires on the first low-time pulse; limit 127 expires on the 128th pulse and not on the 127th.
- R9: A clock line already held low when reset is released is timed from reset. This is the case of a master wanting to start while another device holds the clock low.
- R10: After an error, no further `errStrobe` pulse is produced until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous host reset |
| cfgByte | input | 8 | Bit 7 enable, bits 6:0 limit V |
| sclIn | input | 1 | Sampled clock line level |
| tick | input | 1 | One-cycle pulse per 143.36 us time unit |
| errStrobe | output | 1 | One-cycle bus-error pulse for the interrupt request |
| statusCode | output | 8 | F8h idle, 78h after a bus error |
| sclRelease | output | 1 | Request to release the clock line |
| sdaRelease | output | 1 | Request to release the data line |

## Verification
The bench drives a tick pulse for one cycle between falling clock edges. The clock edge inside that pulse is where the expiry is decided. `errStrobe`, `statusCode` and both release outputs change one register later, so they are sampled at the next falling edge, directly after the pulse. `errStrobe` is sampled again one cycle later to confirm it has dropped. Clock-line changes and configuration writes are each given a full cycle of their own before any tick follows. This keeps a reload from ever coinciding with a counted pulse.

// File: rtl/wdPkg.sv
package wdPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic reload;     // load counter from the limit field
    logic countDown;  // consume one tick of low time
  } wdCtl_t;

  localparam logic [7:0] BUS_ERR_CODE = 8'h78;
  localparam logic [7:0] IDLE_CODE    = 8'hF8;
endpackage

// File: rtl/wdDatapath.sv
module wdDatapath
  import wdPkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic [CNT_W-1:0] reloadVal,
  input  wdCtl_t           ctl,
  output logic             sclEdge,
  output logic             countZero
);
  logic             sclPrev;
  logic [CNT_W-1:0] count;

  // Released line idles high, so the reset value is 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclPrev <= 1'b1;
    else       sclPrev <= sclIn;
  end

  assign sclEdge = sclIn ^ sclPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (ctl.reload)    count <= reloadVal;
    else if (ctl.countDown) count <= count - 1'b1;
  end

  assign countZero = (count == '0);
endmodule

// File: rtl/wdControl.sv
module wdControl
  import wdPkg::*;
#(
  parameter logic [7:0] ERR_CODE  = BUS_ERR_CODE,
  parameter logic [7:0] IDLE_VAL  = IDLE_CODE
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tick,
  input  logic       sclIn,
  input  logic       sclEdge,
  input  logic       countZero,
  output wdCtl_t     ctl,
  output logic       errStrobe,
  output logic       errLatched,
  output logic [7:0] statusCode
);
  logic primed;
  logic active;
  logic lowTick;
  logic expire;

  assign active  = primed && !errLatched;
  // A tick counts only while low, enabled and not on a reload cycle
  assign lowTick = active && enable && !sclEdge && !sclIn && tick;
  assign expire  = lowTick && countZero;

  always_comb begin
    ctl           = '0;
    ctl.reload    = !primed || (active && (sclEdge || !enable));
    ctl.countDown = lowTick && !countZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed     <= 1'b0;
      errLatched <= 1'b0;
      errStrobe  <= 1'b0;
    end else begin
      primed    <= 1'b1;
      errStrobe <= expire;
      if (expire) errLatched <= 1'b1;
    end
  end

  assign statusCode = errLatched ? ERR_CODE : IDLE_VAL;
endmodule

// File: rtl/sclLowWatchdog.sv
module sclLowWatchdog
  import wdPkg::*;
#(
  parameter int         CFG_W    = 8,
  parameter logic [7:0] ERR_CODE = BUS_ERR_CODE,
  parameter logic [7:0] IDLE_VAL = IDLE_CODE
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgByte,
  input  logic             sclIn,
  input  logic             tick,
  output logic             errStrobe,
  output logic [7:0]       statusCode,
  output logic             sclRelease,
  output logic             sdaRelease
);
  localparam int CNT_W = CFG_W - 1;

  wdCtl_t ctl;
  logic   sclEdge;
  logic   countZero;
  logic   errLatched;

  wdDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .reloadVal (cfgByte[CNT_W-1:0]),
    .ctl       (ctl),
    .sclEdge   (sclEdge),
    .countZero (countZero)
  );

  wdControl #(.ERR_CODE(ERR_CODE), .IDLE_VAL(IDLE_VAL)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (cfgByte[CFG_W-1]),
    .tick       (tick),
    .sclIn      (sclIn),
    .sclEdge    (sclEdge),
    .countZero  (countZero),
    .ctl        (ctl),
    .errStrobe  (errStrobe),
    .errLatched (errLatched),
    .statusCode (statusCode)
  );

  assign sclRelease = errLatched;
  assign sdaRelease = errLatched;
endmodule

// File: rtl/wdChecker.sv
module wdChecker #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [CFG_W-1:0] cfgByte,
  input logic             sclIn,
  input logic             tick,
  input logic             errStrobe,
  input logic [7:0]       statusCode,
  input logic             sclRelease,
  input logic             sdaRelease
);
  // R6: both lines released together, with the error code shown
  p_release_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sclRelease == sdaRelease) && (sclRelease == (statusCode == 8'h78)));

  // R6: strobe marks the entry into the error state
  p_strobe_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> (sclRelease && !$past(sclRelease)));

  // R10: strobe lasts a single cycle and never repeats
  p_strobe_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |=> !errStrobe);

  // R7: error state sticky until reset
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    sclRelease |=> sclRelease);

  // R5: an error needs the enable bit at the expiring edge
  p_needs_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> $past(cfgByte[CFG_W-1]));

  // R2/R3: an error needs a tick pulse with the clock line low
  p_needs_low_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> ($past(tick) && !$past(sclIn)));
endmodule

bind sclLowWatchdog wdChecker #(.CFG_W(CFG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgByte    (cfgByte),
  .sclIn      (sclIn),
  .tick       (tick),
  .errStrobe  (errStrobe),
  .statusCode (statusCode),
  .sclRelease (sclRelease),
  .sdaRelease (sdaRelease)
);

// File: tb/tb_sclLowWatchdog.sv
module tb_sclLowWatchdog;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cfgByte = 8'h00;
  logic       sclIn = 1'b1;
  logic       tick = 1'b0;
  logic       errStrobe;
  logic [7:0] statusCode;
  logic       sclRelease;
  logic       sdaRelease;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sclLowWatchdog dut (
    .clk(clk), .rstN(rstN), .cfgByte(cfgByte), .sclIn(sclIn), .tick(tick),
    .errStrobe(errStrobe), .statusCode(statusCode),
    .sclRelease(sclRelease), .sdaRelease(sdaRelease)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Full output vector: {strobe, code, sclRel, sdaRel}
  task automatic checkOut(input string req, input bit strobe, input bit err);
    logic [10:0] act, exp;
    act = {errStrobe, statusCode, sclRelease, sdaRelease};
    exp = {strobe, err ? 8'h78 : 8'hF8, err, err};
    check(act == exp, req, int'(act), int'(exp));
  endtask

  task automatic doReset(input logic sclLevel, input logic [7:0] cfg);
    @(negedge clk);
    rstN = 1'b0; sclIn = sclLevel; cfgByte = cfg; tick = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic setScl(input logic v);
    sclIn = v;
    @(negedge clk);
  endtask

  // One tick pulse; outputs due at the following falling edge
  task automatic pulseTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      pulseTick();
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    doReset(1'b1, 8'h85);
    checkOut("R1", 1'b0, 1'b0);
  endtask

  task automatic testBasic();
    doReset(1'b1, 8'h85);
    setScl(1'b0);
    ticks(5);
    checkOut("R2 before limit", 1'b0, 1'b0);
    pulseTick();
    checkOut("R2 expiry R6", 1'b1, 1'b1);
    @(negedge clk);
    checkOut("R6 strobe one cycle", 1'b0, 1'b1);
  endtask

  task automatic testHighIgnored();
    doReset(1'b1, 8'h81);
    ticks(10);
    checkOut("R3 high ticks ignored", 1'b0, 1'b0);
    setScl(1'b0);
    pulseTick();
    checkOut("R3 first low tick", 1'b0, 1'b0);
    @(negedge clk);
    pulseTick();
    checkOut("R3 second low tick", 1'b1, 1'b1);
  endtask

  task automatic testReload();
    doReset(1'b1, 8'h83);
    setScl(1'b0);
    ticks(3);
    setScl(1'b1);
    setScl(1'b0);
    ticks(3);
    checkOut("R4 reload after toggle", 1'b0, 1'b0);
    pulseTick();
    checkOut("R4 full period again", 1'b1, 1'b1);
  endtask

  task automatic testDisabled();
    doReset(1'b1, 8'h02);
    setScl(1'b0);
    ticks(200);
    checkOut("R5 disabled no error", 1'b0, 1'b0);
    cfgByte = 8'h82;
    @(negedge clk);
    ticks(2);
    checkOut("R5 reenabled full period", 1'b0, 1'b0);
    pulseTick();
    checkOut("R5 expiry after reenable", 1'b1, 1'b1);
  endtask

  task automatic testSticky();
    doReset(1'b1, 8'h80);
    setScl(1'b0);
    pulseTick();
    checkOut("R8 limit zero", 1'b1, 1'b1);
    @(negedge clk);
    ticks(5);
    checkOut("R10 no repeat strobe", 1'b0, 1'b1);
    setScl(1'b1);
    setScl(1'b0);
    cfgByte = 8'h00;
    @(negedge clk);
    checkOut("R7 sticky", 1'b0, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R7 cleared by reset", 1'b0, 1'b0);
  endtask

  task automatic testMaxLimit();
    doReset(1'b1, 8'hFF);
    setScl(1'b0);
    ticks(127);
    checkOut("R8 limit 127 not yet", 1'b0, 1'b0);
    pulseTick();
    checkOut("R8 limit 127 expiry", 1'b1, 1'b1);
  endtask

  task automatic testHeldFromReset();
    doReset(1'b0, 8'h81);
    pulseTick();
    checkOut("R9 held low first tick", 1'b0, 1'b0);
    @(negedge clk);
    pulseTick();
    checkOut("R9 held low expiry", 1'b1, 1'b1);
  endtask

  initial begin
    testReset();
    testBasic();
    testHighIgnored();
    testReload();
    testDisabled();
    testSticky();
    testMaxLimit();
    testHeldFromReset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule